// File: doc/BRIEF.md
# Bidirectional Dual-FIFO Port Access Decoder

This block sits between the two external ports of a bidirectional FIFO pair and the two FIFO cores. The forward FIFO is filled from port A and drained onto port B; the return FIFO is filled from port B and drained onto port A. Each port has its own clock and its own synchronous active-low reset. Each port also has a chip select (active low), a direction select, an access enable and a mailbox select, and it receives two flags from the FIFO cores: one saying whether the FIFO that port fills can take a word, and one saying whether the FIFO that port drains has a word. From these inputs the block produces single-cycle push and pop strobes for the FIFO cores, mailbox write and read strobes for a separate mailbox path, and a 36-bit drive enable for each port's data bus.

The direction select has opposite meaning on the two ports. On port A a high level means the port writes. On port B a high level means the port reads. A port's bus is driven only when that port is selected and reading. The drive enables are registered, so the tri-state control changes only on a clock edge of the owning port and never glitches. The strobes are combinational and take effect on the next rising edge of the owning port's clock. Each port is decoded from its own inputs alone, so the two ports work at the same time without interfering.

Top module: `bififo_port_decoder`

## Requirements
- R1: `fwd_push` is high exactly when `rst_a_n`=1, `csa_n`=0, `dira`=1, `ena`=1, `mboxa`=0 and `fwd_room`=1.
- R2: `ret_pop` is high exactly when `rst_a_n`=1, `csa_n`=0, `dira`=0, `ena`=1, `mboxa`=0 and `ret_avail`=1.
- R3: `ret_push` is high exactly when `rst_b_n`=1, `csb_n`=0, `dirb`=0, `enb`=1, `mboxb`=0 and `ret_room`=1.
- R4: `fwd_pop` is high exactly when `rst_b_n`=1, `csb_n`=0, `dirb`=1, `enb`=1, `mboxb`=0 and `fwd_avail`=1.
- R5: When a port's mailbox select is 1, that port's push and pop strobes stay low. The port's mailbox write strobe (or mailbox read strobe) is high when the port is selected, enabled and writing (or reading). This does not depend on the ready flags.
- R6: `a_drive` is all ones in the `clk_a` cycle after an edge that sampled `csa_n`=0 and `dira`=0, and all zeros after any other edge. A change on these inputs has no effect on `a_drive` before the next `clk_a` edge.
- R7: `b_drive` is all ones in the `clk_b` cycle after an edge that sampled `csb_n`=0 and `dirb`=1, and all zeros after any other edge.
- R8: While a port's reset is low, all of that port's strobes are low. A `clk` edge with the port's reset low clears that port's drive enable to zero.
- R9: The strobes and drive enable of each port depend only on that port's inputs, so different operations on the two ports at the same time each give their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| csa_n | input | 1 | Port A chip select, active low |
| dira | input | 1 | Port A direction: 1 write, 0 read |
| ena | input | 1 | Port A access enable |
| mboxa | input | 1 | Port A mailbox select |
| fwd_room | input | 1 | Forward FIFO can accept a word |
| ret_avail | input | 1 | Return FIFO holds a word for port A |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| csb_n | input | 1 | Port B chip select, active low |
| dirb | input | 1 | Port B direction: 1 read, 0 write |
| enb | input | 1 | Port B access enable |
| mboxb | input | 1 | Port B mailbox select |
| ret_room | input | 1 | Return FIFO can accept a word |
| fwd_avail | input | 1 | Forward FIFO holds a word for port B |
| fwd_push | output | 1 | Write strobe into the forward FIFO (port A) |
| ret_pop | output | 1 | Read strobe from the return FIFO (port A) |
| ret_push | output | 1 | Write strobe into the return FIFO (port B) |
| fwd_pop | output | 1 | Read strobe from the forward FIFO (port B) |
| a_mbox_wr | output | 1 | Port A mailbox write strobe |
| a_mbox_rd | output | 1 | Port A mailbox read strobe |
| b_mbox_wr | output | 1 | Port B mailbox write strobe |
| b_mbox_rd | output | 1 | Port B mailbox read strobe |
| a_drive | output | 36 | Per-bit drive enable for the port A data bus |
| b_drive | output | 36 | Per-bit drive enable for the port B data bus |

## Verification
The strobes are pure decode, so a wrong polarity choice or a lost qualifier shows up at once. It appears as a push or pop in the same cycle as the bad input combination, and it corrupts a FIFO on the very next edge. The only state in the block is the drive-enable register. If it is stale or was not cleared, the bus drives in the wrong direction for exactly one cycle after the select inputs change, or stays driven through reset. The bench therefore samples each drive enable both before and after the owning clock edge. It also feeds the two ports different combinations in the same cycle, which exposes any path that crosses between the ports.

// File: rtl/bfd_pkg.sv
// Package: shared types for the bidirectional FIFO port decoder.
// Assumes: nothing; holds only type and constant definitions.
package bfd_pkg;

    // Number of external ports decoded by the block.
    localparam int unsigned NUM_PORTS = 2;

    // Strobes produced for one port in one cycle.
    typedef struct packed {
        logic push;     // store a word into the FIFO this port fills
        logic pop;      // take a word from the FIFO this port drains
        logic mbox_wr;  // mailbox write access
        logic mbox_rd;  // mailbox read access
    } port_strobe_t;

endpackage

// File: rtl/bfd_access_decode.sv
// Module: bfd_access_decode
// Decodes one port's control inputs into FIFO and mailbox strobes.
// Assumes: all inputs are synchronous to the port clock; WRITE_LEVEL is
// the level of the direction input that means "write" for this port.
module bfd_access_decode
    import bfd_pkg::*;
#(
    parameter bit WRITE_LEVEL = 1'b1
) (
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         dir,
    input  logic         en,
    input  logic         mbox,
    input  logic         room,
    input  logic         avail,
    output port_strobe_t strobe
);

    logic live;      // port out of reset, selected and enabled
    logic is_write;  // direction decoded into write intent

    // Qualify the access and normalise the direction polarity.
    always_comb begin
        live     = rst_n & ~cs_n & en;
        is_write = (dir == WRITE_LEVEL);
    end

    // Steer the access to either the FIFO path or the mailbox path.
    always_comb begin
        strobe.push    = live & ~mbox &  is_write & room;
        strobe.pop     = live & ~mbox & ~is_write & avail;
        strobe.mbox_wr = live &  mbox &  is_write;
        strobe.mbox_rd = live &  mbox & ~is_write;
    end

endmodule

// File: rtl/bfd_drive_reg.sv
// Module: bfd_drive_reg
// Registered per-bit drive enable for one port's data bus.
// Assumes: synchronous active-low reset; every bit has its own flop so that
// each pad driver gets a local, glitch-free enable.
module bfd_drive_reg #(
    parameter int unsigned DATA_W      = 36,
    parameter bit          WRITE_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dir,
    output logic [DATA_W-1:0] drive
);

    logic want_drive;  // port selected and reading this cycle

    // Drive only when this port reads (direction opposite to write level).
    always_comb begin
        want_drive = ~cs_n & (dir != WRITE_LEVEL);
    end

    // One flop per bus bit; cleared in reset.
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            // Capture the drive decision for bit b.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    drive[b] <= 1'b0;
                end else begin
                    drive[b] <= want_drive;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bfd_port.sv
// Module: bfd_port
// One port of the decoder: strobe decode plus the registered drive enable.
// Assumes: all inputs are synchronous to clk.
module bfd_port
    import bfd_pkg::*;
#(
    parameter int unsigned DATA_W      = 36,
    parameter bit          WRITE_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dir,
    input  logic              en,
    input  logic              mbox,
    input  logic              room,
    input  logic              avail,
    output port_strobe_t      strobe,
    output logic [DATA_W-1:0] drive
);

    bfd_access_decode #(
        .WRITE_LEVEL (WRITE_LEVEL)
    ) u_decode (
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .dir    (dir),
        .en     (en),
        .mbox   (mbox),
        .room   (room),
        .avail  (avail),
        .strobe (strobe)
    );

    bfd_drive_reg #(
        .DATA_W      (DATA_W),
        .WRITE_LEVEL (WRITE_LEVEL)
    ) u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .dir   (dir),
        .drive (drive)
    );

endmodule

// File: rtl/bififo_port_decoder.sv
// Module: bififo_port_decoder
// Top of the bidirectional FIFO-pair port decoder. Port A fills the forward
// FIFO and drains the return FIFO; port B fills the return FIFO and drains
// the forward FIFO. Each port runs on its own clock and reset.
// Assumes: each port's inputs are synchronous to that port's clock; the
// ready flags come from logic already in that port's clock domain.
module bififo_port_decoder
    import bfd_pkg::*;
#(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              csa_n,
    input  logic              dira,
    input  logic              ena,
    input  logic              mboxa,
    input  logic              fwd_room,
    input  logic              ret_avail,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              csb_n,
    input  logic              dirb,
    input  logic              enb,
    input  logic              mboxb,
    input  logic              ret_room,
    input  logic              fwd_avail,
    output logic              fwd_push,
    output logic              ret_pop,
    output logic              ret_push,
    output logic              fwd_pop,
    output logic              a_mbox_wr,
    output logic              a_mbox_rd,
    output logic              b_mbox_wr,
    output logic              b_mbox_rd,
    output logic [DATA_W-1:0] a_drive,
    output logic [DATA_W-1:0] b_drive
);

    // Index 0 is port A, index 1 is port B.
    localparam bit [NUM_PORTS-1:0] WRITE_LEVELS = 2'b01;

    logic [NUM_PORTS-1:0] p_clk, p_rst_n, p_cs_n, p_dir, p_en, p_mbox;
    logic [NUM_PORTS-1:0] p_room, p_avail;
    port_strobe_t         p_strobe [NUM_PORTS];
    logic [DATA_W-1:0]    p_drive  [NUM_PORTS];

    // Gather the per-port pins into indexed vectors.
    always_comb begin
        p_clk   = {clk_b,    clk_a};
        p_rst_n = {rst_b_n,  rst_a_n};
        p_cs_n  = {csb_n,    csa_n};
        p_dir   = {dirb,     dira};
        p_en    = {enb,      ena};
        p_mbox  = {mboxb,    mboxa};
        p_room  = {ret_room, fwd_room};
        p_avail = {fwd_avail, ret_avail};
    end

    // One identical port slice per port, differing only in write polarity.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            bfd_port #(
                .DATA_W      (DATA_W),
                .WRITE_LEVEL (WRITE_LEVELS[p])
            ) u_port (
                .clk    (p_clk[p]),
                .rst_n  (p_rst_n[p]),
                .cs_n   (p_cs_n[p]),
                .dir    (p_dir[p]),
                .en     (p_en[p]),
                .mbox   (p_mbox[p]),
                .room   (p_room[p]),
                .avail  (p_avail[p]),
                .strobe (p_strobe[p]),
                .drive  (p_drive[p])
            );
        end
    endgenerate

    // Route port strobes to the FIFO each one targets.
    always_comb begin
        fwd_push  = p_strobe[0].push;
        ret_pop   = p_strobe[0].pop;
        a_mbox_wr = p_strobe[0].mbox_wr;
        a_mbox_rd = p_strobe[0].mbox_rd;
        ret_push  = p_strobe[1].push;
        fwd_pop   = p_strobe[1].pop;
        b_mbox_wr = p_strobe[1].mbox_wr;
        b_mbox_rd = p_strobe[1].mbox_rd;
        a_drive   = p_drive[0];
        b_drive   = p_drive[1];
    end

endmodule

// File: rtl/bfd_checker.sv
// Module: bfd_checker
// Assertion checker for bififo_port_decoder, attached with bind below.
// Assumes: inputs are stable around each port's rising clock edge.
module bfd_checker #(
    parameter int unsigned DATA_W = 36
) (
    input logic              clk_a,
    input logic              rst_a_n,
    input logic              csa_n,
    input logic              dira,
    input logic              ena,
    input logic              mboxa,
    input logic              fwd_room,
    input logic              ret_avail,
    input logic              clk_b,
    input logic              rst_b_n,
    input logic              csb_n,
    input logic              dirb,
    input logic              enb,
    input logic              mboxb,
    input logic              ret_room,
    input logic              fwd_avail,
    input logic              fwd_push,
    input logic              ret_pop,
    input logic              ret_push,
    input logic              fwd_pop,
    input logic              a_mbox_wr,
    input logic              a_mbox_rd,
    input logic              b_mbox_wr,
    input logic              b_mbox_rd,
    input logic [DATA_W-1:0] a_drive,
    input logic [DATA_W-1:0] b_drive
);

    localparam logic [DATA_W-1:0] ALL_ON = {DATA_W{1'b1}};

    assert_fwd_push_qualified_R1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        fwd_push |-> (!csa_n && dira && ena && !mboxa && fwd_room));

    assert_ret_pop_qualified_R2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        ret_pop |-> (!csa_n && !dira && ena && !mboxa && ret_avail));

    assert_ret_push_qualified_R3: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        ret_push |-> (!csb_n && !dirb && enb && !mboxb && ret_room));

    assert_fwd_pop_qualified_R4: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        fwd_pop |-> (!csb_n && dirb && enb && !mboxb && fwd_avail));

    assert_mbox_blocks_fifo_a_R5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        mboxa |-> (!fwd_push && !ret_pop));

    assert_mbox_blocks_fifo_b_R5: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        mboxb |-> (!ret_push && !fwd_pop));

    assert_a_drive_on_R6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!csa_n && !dira) |=> (a_drive == ALL_ON));

    assert_a_drive_off_R6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (csa_n || dira) |=> (a_drive == '0));

    assert_b_drive_on_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!csb_n && dirb) |=> (b_drive == ALL_ON));

    assert_b_drive_off_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (csb_n || !dirb) |=> (b_drive == '0));

    // R8: no strobe of a port while that port's reset is low.
    always_comb begin
        if (rst_a_n === 1'b0) begin
            assert_reset_quiet_a_R8: assert (!fwd_push && !ret_pop && !a_mbox_wr && !a_mbox_rd);
        end
        if (rst_b_n === 1'b0) begin
            assert_reset_quiet_b_R8: assert (!ret_push && !fwd_pop && !b_mbox_wr && !b_mbox_rd);
        end
    end

endmodule

bind bififo_port_decoder bfd_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bififo_port_decoder_tb.sv
// Bench: vector table walked on both ports at once, then directed tests.
module bififo_port_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 36;
    localparam int NVEC       = 12;

    // Vector fields: cs_n, write intent, en, mbox, room, avail,
    //                exp push, exp pop, exp mbox_wr, exp mbox_rd, exp drive.
    typedef struct packed {
        logic cs_n, wr, en, mb, room, avail;
        logic e_push, e_pop, e_mwr, e_mrd, e_drv;
    } vec_t;

    localparam logic [10:0] VECS [NVEC] = '{
        11'b0_1_1_0_1_0_1_0_0_0_0,  // write, room: push
        11'b0_1_1_0_0_1_0_0_0_0_0,  // write, no room
        11'b0_0_1_0_0_1_0_1_0_0_1,  // read, avail: pop, drive
        11'b0_0_1_0_1_0_0_0_0_0_1,  // read, empty: drive only
        11'b1_1_1_0_1_1_0_0_0_0_0,  // deselected write
        11'b1_0_1_0_1_1_0_0_0_0_0,  // deselected read
        11'b0_1_0_0_1_1_0_0_0_0_0,  // write, not enabled
        11'b0_0_0_0_1_1_0_0_0_0_1,  // read, not enabled: still drive
        11'b0_1_1_1_1_1_0_0_1_0_0,  // mailbox write
        11'b0_0_1_1_1_1_0_0_0_1_1,  // mailbox read
        11'b0_1_1_1_0_0_0_0_1_0_0,  // mailbox write, flags low
        11'b1_1_1_1_1_1_0_0_0_0_0   // mailbox, deselected
    };

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic csa_n = 1'b1, dira = 1'b0, ena = 1'b0, mboxa = 1'b0, fwd_room = 1'b0, ret_avail = 1'b0;
    logic csb_n = 1'b1, dirb = 1'b0, enb = 1'b0, mboxb = 1'b0, ret_room = 1'b0, fwd_avail = 1'b0;
    logic fwd_push, ret_pop, ret_push, fwd_pop;
    logic a_mbox_wr, a_mbox_rd, b_mbox_wr, b_mbox_rd;
    logic [DATA_W-1:0] a_drive, b_drive;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk_a = ~clk_a;
    initial begin
        #3;
        forever #(CLK_PERIOD/2) clk_b = ~clk_b;
    end

    bififo_port_decoder #(.DATA_W(DATA_W)) u_dut (.*);

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_a(input vec_t v);
        csa_n = v.cs_n; dira = v.wr; ena = v.en; mboxa = v.mb;
        fwd_room = v.room; ret_avail = v.avail;
    endtask

    task automatic drive_b(input vec_t v);
        csb_n = v.cs_n; dirb = ~v.wr; enb = v.en; mboxb = v.mb;
        ret_room = v.room; fwd_avail = v.avail;
    endtask

    function automatic logic [DATA_W-1:0] fill(input logic b);
        return b ? {DATA_W{1'b1}} : '0;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state with active-looking inputs on both ports.
        @(negedge clk_a);
        drive_a(vec_t'(VECS[2]));
        drive_b(vec_t'(VECS[2]));
        #1;
        check("R8 ret_pop in reset", ret_pop, '0);
        check("R8 fwd_pop in reset", fwd_pop, '0);
        repeat (2) @(posedge clk_b);
        #1;
        check("R8 a_drive in reset", a_drive, '0);
        check("R8 b_drive in reset", b_drive, '0);

        // Release both resets; strobe returns at once (R2, R4).
        @(negedge clk_a);
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;
        #1;
        check("R2 ret_pop after reset", ret_pop, 1'b1);
        check("R4 fwd_pop after reset", fwd_pop, 1'b1);

        // Table walk: port B gets a different row than port A (R9).
        for (int i = 0; i < NVEC; i++) begin
            vec_t va, vb;
            va = vec_t'(VECS[i]);
            vb = vec_t'(VECS[(i + 5) % NVEC]);
            @(negedge clk_a);
            drive_a(va);
            drive_b(vb);
            #1;
            check($sformatf("R1 R9 fwd_push row %0d", i), fwd_push, va.e_push);
            check($sformatf("R2 R9 ret_pop row %0d", i), ret_pop, va.e_pop);
            check($sformatf("R5 a_mbox_wr row %0d", i), a_mbox_wr, va.e_mwr);
            check($sformatf("R5 a_mbox_rd row %0d", i), a_mbox_rd, va.e_mrd);
            check($sformatf("R3 R9 ret_push row %0d", i), ret_push, vb.e_push);
            check($sformatf("R4 R9 fwd_pop row %0d", i), fwd_pop, vb.e_pop);
            check($sformatf("R5 b_mbox_wr row %0d", i), b_mbox_wr, vb.e_mwr);
            check($sformatf("R5 b_mbox_rd row %0d", i), b_mbox_rd, vb.e_mrd);
            @(posedge clk_a);
            @(posedge clk_b);
            #1;
            check($sformatf("R6 a_drive row %0d", i), a_drive, fill(va.e_drv));
            check($sformatf("R7 b_drive row %0d", i), b_drive, fill(vb.e_drv));
        end

        // R6: drive enable waits for the edge.
        @(negedge clk_a);
        drive_a(vec_t'(VECS[0]));
        @(posedge clk_a);
        #1;
        check("R6 a_drive off for write", a_drive, '0);
        @(negedge clk_a);
        drive_a(vec_t'(VECS[3]));
        #1;
        check("R6 a_drive unchanged before edge", a_drive, '0);
        @(posedge clk_a);
        #1;
        check("R6 a_drive on after edge", a_drive, fill(1'b1));

        // R7: port B read polarity, then reset clears it (R8).
        @(negedge clk_a);
        drive_b(vec_t'(VECS[3]));
        @(posedge clk_b);
        #1;
        check("R7 b_drive on with dirb high", b_drive, fill(1'b1));
        check("R7 dirb level for read", {35'd0, dirb}, 36'd1);
        @(negedge clk_a);
        rst_b_n = 1'b0;
        drive_b(vec_t'(VECS[0]));
        #1;
        check("R8 ret_push held in reset", ret_push, '0);
        check("R9 port A unaffected by port B reset", a_drive, fill(1'b1));
        @(posedge clk_b);
        #1;
        check("R8 b_drive cleared by reset", b_drive, '0);
        @(negedge clk_a);
        rst_b_n = 1'b1;
        #1;
        check("R3 ret_push after reset release", ret_push, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule